// File: doc/BRIEF.md
# Reorder Buffer with Operand Forwarding

This block sits between instruction issue and the register file of a pipeline whose functional units finish out of program order. Every issued instruction claims the entry at the allocation pointer, and the entry index is handed back as the tag that the finishing unit later returns with its result. Results and exception flags may arrive in any order. Entries leave strictly from the oldest end. Each departing entry either writes its destination register or, if it is a store marker, releases one held store to memory.

When the oldest entry finished with an exception, retirement freezes. Issue is refused and the program counter recorded for that entry is presented as the restart address. Both stay in place until reset. While entries wait, two source-operand designators from the instruction at issue are compared against the buffered destinations. A finished result is steered into the operand path in place of register-file data. A match on an unfinished entry raises a per-operand wait flag.

Top module: `rob_bypass_buffer`

## Requirements
- R1: An accepted issue receives the current allocation index on `iss_tag`, starting at 0 after reset. The index then advances by one and wraps from DEPTH-1 to 0.
- R2: A completion writes `cmp_data` and the OR of `cmp_exc` into the entry named by `cmp_tag`. Completions may arrive in any order.
- R3: An entry can retire only when it is the oldest and has finished with `cmp_exc` all zero. If it was issued with `iss_wen`=1 and `iss_store`=0, retirement drives `cm_we` high for that one cycle, with its destination on `cm_addr` and its result on `cm_data`. A finished younger entry waits behind an unfinished older one.
- R4: If the oldest entry finished with a nonzero exception, it does not retire and nothing behind it retires. `exc_stop` rises one cycle later and stays high until reset. While it is high, `cm_we` and `st_release` stay low and issue is refused.
- R5: When `exc_stop` rises, `exc_pc` holds the `iss_pc` given at issue to the faulting entry.
- R6: A source designator that matches the forwarding entry of that register, where that entry has finished, yields that entry's result on the operand output with its wait flag low. A source designator with no matching entry yields the register-file input unchanged with its wait flag low.
- R7: Allocating a new entry for register r disables forwarding from every older entry for r. Only the newest entry for r can match. A match on an unfinished entry raises the wait flag and passes the register-file input through.
- R8: An entry issued with `iss_store`=1 pulses `st_release` for one cycle when it retires and never drives `cm_we`.
- R9: `full` is high when DEPTH entries are held. An issue request while full allocates nothing, and the tag does not advance.
- R10: After reset the buffer is empty. `full`, `exc_stop`, `cm_we` and `st_release` are low, and `iss_tag` and `exc_pc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_dst | input | AW | Destination register of issuing instruction |
| iss_wen | input | 1 | Issuing instruction writes a register |
| iss_store | input | 1 | Issuing instruction is a store marker |
| iss_pc | input | PCW | Program counter of issuing instruction |
| iss_tag | output | PW | Tag allocated to the issuing instruction |
| full | output | 1 | All entries held; issue stalls |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | PW | Entry addressed by completion |
| cmp_data | input | DW | Completed result |
| cmp_exc | input | EW | Exception flags of completed instruction |
| src_a | input | AW | First source designator at issue |
| src_b | input | AW | Second source designator at issue |
| rf_a_data | input | DW | Register-file read for first source |
| rf_b_data | input | DW | Register-file read for second source |
| opa_data | output | DW | First operand after forwarding |
| opb_data | output | DW | Second operand after forwarding |
| opa_wait | output | 1 | First operand matches an unfinished entry |
| opb_wait | output | 1 | Second operand matches an unfinished entry |
| cm_we | output | 1 | Register commit strobe |
| cm_addr | output | AW | Register commit address |
| cm_data | output | DW | Register commit data |
| st_release | output | 1 | Release one held store to memory |
| exc_stop | output | 1 | Precise stop after an exception |
| exc_pc | output | PCW | Program counter of the faulting instruction |

## Verification
The checks assume that completions arrive only for tags that are currently held and never twice for the same entry. They also assume an entry is never flagged as both a register writer and a store marker in a way that would drive both commit strobes. The directed stimulus returns each tag it was handed exactly once, and it keeps completions for the same tag apart from the issue that reuses it. Operand lookups are made while no completion for the looked-up entry is in flight, so forwarding reflects entry state that has settled.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    RET_NONE  = 2'd0,
    RET_REG   = 2'd1,
    RET_STORE = 2'd2,
    RET_QUIET = 2'd3
  } ret_kind_e;

  // Classify what the retiring entry does to architectural state.
  function automatic ret_kind_e ret_classify(input logic fire,
                                             input logic wen,
                                             input logic store);
    if (!fire)      return RET_NONE;
    else if (store) return RET_STORE;
    else if (wen)   return RET_REG;
    else            return RET_QUIET;
  endfunction

  // An entry can forward only while held, enabled, writing, and matching.
  function automatic logic fwd_hit(input logic held, input logic enabled,
                                   input logic writes, input logic same_reg);
    return held & enabled & writes & same_reg;
  endfunction

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl #(
  parameter int DEPTH = 8,
  parameter int PCW   = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_req,
  input  logic           head_done,
  input  logic           head_exc,
  input  logic [PCW-1:0] head_pc,
  output logic [PW-1:0]  tail,
  output logic [PW-1:0]  head,
  output logic [CW-1:0]  occ_cnt,
  output logic           full,
  output logic           iss_fire,
  output logic           retire_fire,
  output logic           stopped,
  output logic [PCW-1:0] stop_pc
);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic head_valid, stop_set;

  assign head_valid  = (occ_cnt != '0);
  assign full        = (occ_cnt == CW'(DEPTH));
  assign iss_fire    = iss_req & ~full & ~stopped;
  assign retire_fire = head_valid & head_done & ~head_exc & ~stopped;
  assign stop_set    = head_valid & head_done & head_exc & ~stopped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail    <= '0;
      head    <= '0;
      occ_cnt <= '0;
      stopped <= 1'b0;
      stop_pc <= '0;
    end else begin
      if (iss_fire)    tail <= bump(tail);
      if (retire_fire) head <= bump(head);
      case ({iss_fire, retire_fire})
        2'b10:   occ_cnt <= occ_cnt + 1'b1;
        2'b01:   occ_cnt <= occ_cnt - 1'b1;
        default: occ_cnt <= occ_cnt;
      endcase
      if (stop_set) begin
        stopped <= 1'b1;
        stop_pc <= head_pc;
      end
    end
  end

endmodule

// File: rtl/rob_fwd.sv
module rob_fwd #(
  parameter int DEPTH = 8,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic [AW-1:0]    src,
  input  logic [DW-1:0]    rf_data,
  input  logic [DEPTH-1:0] held,
  input  logic [DEPTH-1:0] byp_en,
  input  logic [DEPTH-1:0] writes,
  input  logic [DEPTH-1:0] done,
  input  logic [AW-1:0]    dst  [DEPTH],
  input  logic [DW-1:0]    data [DEPTH],
  output logic [DW-1:0]    op_data,
  output logic             op_wait
);

  logic [DEPTH-1:0] hit;
  logic [DW-1:0]    fwd_val;
  logic             fwd_ok;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = rob_pkg::fwd_hit(held[i], byp_en[i], writes[i], dst[i] == src);
  end

  always_comb begin
    fwd_val = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i] && done[i]) fwd_val = fwd_val | data[i];
    end
  end

  assign fwd_ok  = |(hit & done);
  assign op_wait = |(hit & ~done);
  assign op_data = fwd_ok ? fwd_val : rf_data;

endmodule

// File: rtl/rob_bypass_buffer.sv
module rob_bypass_buffer #(
  parameter int DEPTH = 8,
  parameter int AW    = 5,
  parameter int DW    = 32,
  parameter int PCW   = 32,
  parameter int EW    = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid,
  input  logic [AW-1:0]  iss_dst,
  input  logic           iss_wen,
  input  logic           iss_store,
  input  logic [PCW-1:0] iss_pc,
  output logic [PW-1:0]  iss_tag,
  output logic           full,
  input  logic           cmp_valid,
  input  logic [PW-1:0]  cmp_tag,
  input  logic [DW-1:0]  cmp_data,
  input  logic [EW-1:0]  cmp_exc,
  input  logic [AW-1:0]  src_a,
  input  logic [AW-1:0]  src_b,
  input  logic [DW-1:0]  rf_a_data,
  input  logic [DW-1:0]  rf_b_data,
  output logic [DW-1:0]  opa_data,
  output logic [DW-1:0]  opb_data,
  output logic           opa_wait,
  output logic           opb_wait,
  output logic           cm_we,
  output logic [AW-1:0]  cm_addr,
  output logic [DW-1:0]  cm_data,
  output logic           st_release,
  output logic           exc_stop,
  output logic [PCW-1:0] exc_pc
);

  localparam int CW   = $clog2(DEPTH + 1);
  localparam int NSRC = 2;

  logic [DEPTH-1:0] held_q, done_q, exc_q, byp_q, wen_q, store_q;
  logic [AW-1:0]    dst_q  [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [PCW-1:0]   pc_q   [DEPTH];

  logic [PW-1:0]    tail, head;
  logic [CW-1:0]    occ_cnt;
  logic             iss_fire, retire_fire;
  rob_pkg::ret_kind_e ret_kind;

  rob_ctrl #(.DEPTH(DEPTH), .PCW(PCW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_req    (iss_valid),
    .head_done  (done_q[head]),
    .head_exc   (exc_q[head]),
    .head_pc    (pc_q[head]),
    .tail       (tail),
    .head       (head),
    .occ_cnt    (occ_cnt),
    .full       (full),
    .iss_fire   (iss_fire),
    .retire_fire(retire_fire),
    .stopped    (exc_stop),
    .stop_pc    (exc_pc)
  );

  assign iss_tag = tail;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        held_q[i]  <= 1'b0;
        done_q[i]  <= 1'b0;
        exc_q[i]   <= 1'b0;
        byp_q[i]   <= 1'b0;
        wen_q[i]   <= 1'b0;
        store_q[i] <= 1'b0;
        dst_q[i]   <= '0;
        data_q[i]  <= '0;
        pc_q[i]    <= '0;
      end else if (iss_fire && tail == PW'(i)) begin
        held_q[i]  <= 1'b1;
        done_q[i]  <= 1'b0;
        exc_q[i]   <= 1'b0;
        byp_q[i]   <= iss_wen & ~iss_store;
        wen_q[i]   <= iss_wen & ~iss_store;
        store_q[i] <= iss_store;
        dst_q[i]   <= iss_dst;
        pc_q[i]    <= iss_pc;
      end else begin
        if (iss_fire && iss_wen && !iss_store && dst_q[i] == iss_dst) byp_q[i] <= 1'b0;
        if (cmp_valid && cmp_tag == PW'(i) && held_q[i]) begin
          done_q[i] <= 1'b1;
          exc_q[i]  <= |cmp_exc;
          data_q[i] <= cmp_data;
        end
        if (retire_fire && head == PW'(i)) begin
          held_q[i] <= 1'b0;
          byp_q[i]  <= 1'b0;
        end
      end
    end
  end

  assign ret_kind   = rob_pkg::ret_classify(retire_fire, wen_q[head], store_q[head]);
  assign cm_we      = (ret_kind == rob_pkg::RET_REG);
  assign st_release = (ret_kind == rob_pkg::RET_STORE);
  assign cm_addr    = dst_q[head];
  assign cm_data    = data_q[head];

  logic [AW-1:0] src_v  [NSRC];
  logic [DW-1:0] rf_v   [NSRC];
  logic [DW-1:0] op_v   [NSRC];
  logic [NSRC-1:0] wait_v;

  assign src_v[0] = src_a;
  assign src_v[1] = src_b;
  assign rf_v[0]  = rf_a_data;
  assign rf_v[1]  = rf_b_data;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    rob_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
      .src    (src_v[s]),
      .rf_data(rf_v[s]),
      .held   (held_q),
      .byp_en (byp_q),
      .writes (wen_q),
      .done   (done_q),
      .dst    (dst_q),
      .data   (data_q),
      .op_data(op_v[s]),
      .op_wait(wait_v[s])
    );
  end

  assign opa_data = op_v[0];
  assign opb_data = op_v[1];
  assign opa_wait = wait_v[0];
  assign opb_wait = wait_v[1];

endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int PCW   = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           iss_fire,
  input logic           retire_fire,
  input logic [CW-1:0]  occ_cnt,
  input logic           cm_we,
  input logic           st_release,
  input logic           exc_stop,
  input logic [PCW-1:0] exc_pc,
  input logic           opa_wait,
  input logic [DW-1:0]  opa_data,
  input logic [DW-1:0]  rf_a_data
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ_cnt <= CW'(DEPTH)); // R9

  AST_ISSUE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_fire && !retire_fire) |=> (occ_cnt == $past(occ_cnt) + 1'b1)); // R1

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    exc_stop |=> exc_stop); // R4

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_stop |-> (!cm_we && !st_release && !iss_fire)); // R4

  AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    exc_stop |=> $stable(exc_pc)); // R5

  AST_WAIT_PASSES_RF: assert property (@(posedge clk) disable iff (!rst_n)
    opa_wait |-> (opa_data == rf_a_data)); // R7

  AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cm_we, st_release})); // R8

endmodule

bind rob_bypass_buffer rob_chk #(.DEPTH(DEPTH), .DW(DW), .PCW(PCW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_fire   (iss_fire),
  .retire_fire(retire_fire),
  .occ_cnt    (occ_cnt),
  .cm_we      (cm_we),
  .st_release (st_release),
  .exc_stop   (exc_stop),
  .exc_pc     (exc_pc),
  .opa_wait   (opa_wait),
  .opa_data   (opa_data),
  .rf_a_data  (rf_a_data)
);

// File: tb/rob_bypass_buffer_bench.sv
module rob_bypass_buffer_bench;

  localparam int DEPTH = 8;
  localparam int AW = 5, DW = 32, PCW = 32, EW = 4, PW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 0, iss_wen = 0, iss_store = 0;
  logic [AW-1:0] iss_dst = '0, src_a = '0, src_b = '0;
  logic [PCW-1:0] iss_pc = '0;
  logic [PW-1:0] iss_tag, cmp_tag = '0;
  logic full, cmp_valid = 0;
  logic [DW-1:0] cmp_data = '0, rf_a_data = '0, rf_b_data = '0;
  logic [EW-1:0] cmp_exc = '0;
  logic [DW-1:0] opa_data, opb_data, cm_data;
  logic opa_wait, opb_wait, cm_we, st_release, exc_stop;
  logic [AW-1:0] cm_addr;
  logic [PCW-1:0] exc_pc;

  int checks = 0, failures = 0, n_we = 0, n_st = 0;
  int exp_tag = 0;

  always #10 clk = ~clk;

  rob_bypass_buffer u_rob_bypass_buffer (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
    .iss_wen(iss_wen), .iss_store(iss_store), .iss_pc(iss_pc), .iss_tag(iss_tag),
    .full(full), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
    .cmp_exc(cmp_exc), .src_a(src_a), .src_b(src_b), .rf_a_data(rf_a_data),
    .rf_b_data(rf_b_data), .opa_data(opa_data), .opb_data(opb_data),
    .opa_wait(opa_wait), .opb_wait(opb_wait), .cm_we(cm_we), .cm_addr(cm_addr),
    .cm_data(cm_data), .st_release(st_release), .exc_stop(exc_stop), .exc_pc(exc_pc)
  );

  always @(negedge clk) begin
    if (cm_we) n_we++;
    if (st_release) n_st++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_issue(input int dst, input bit wen, input bit st, input int pc);
    iss_valid = 1; iss_dst = AW'(dst); iss_wen = wen; iss_store = st; iss_pc = PCW'(pc);
    #1 chk(iss_tag == PW'(exp_tag), "R1 tag", 32'(iss_tag), 32'(exp_tag));
    tick();
    iss_valid = 0;
    exp_tag = (exp_tag + 1) % DEPTH;
  endtask

  task automatic do_cmp(input int tag, input int data, input int exc);
    cmp_valid = 1; cmp_tag = PW'(tag); cmp_data = DW'(data); cmp_exc = EW'(exc);
    tick();
    cmp_valid = 0; cmp_exc = '0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    exp_tag = 0;
    #1;
    chk(full == 0 && exc_stop == 0, "R10 flags", {30'd0, full, exc_stop}, 0);
    chk(iss_tag == 0 && exc_pc == 0, "R10 tag/pc", exc_pc | 32'(iss_tag), 0);
    chk(cm_we == 0 && st_release == 0, "R10 commit idle", {30'd0, cm_we, st_release}, 0);
  endtask

  task automatic t_order();
    do_issue(1, 1, 0, 32'h100);
    do_issue(2, 1, 0, 32'h104);
    do_cmp(1, 32'h22, 0);
    chk(cm_we == 0, "R3 younger waits", 32'(cm_we), 0);
    do_cmp(0, 32'h11, 0);
    chk(cm_we && cm_addr == 1 && cm_data == 32'h11, "R2 R3 first commit", cm_data, 32'h11);
    tick();
    chk(cm_we && cm_addr == 2 && cm_data == 32'h22, "R2 R3 second commit", cm_data, 32'h22);
    tick();
    chk(cm_we == 0, "R3 idle after drain", 32'(cm_we), 0);
  endtask

  task automatic t_bypass();
    do_issue(4, 1, 0, 32'h200);
    do_issue(3, 1, 0, 32'h204);
    src_a = 3; rf_a_data = 32'hAAAA; src_b = 9; rf_b_data = 32'hBBBB;
    #1 chk(opa_wait == 1 && opa_data == 32'hAAAA, "R7 pending waits", opa_data, 32'hAAAA);
    do_cmp(3, 32'h33, 0);
    chk(opa_wait == 0 && opa_data == 32'h33, "R6 forward finished", opa_data, 32'h33);
    chk(opb_wait == 0 && opb_data == 32'hBBBB, "R6 no match passes rf", opb_data, 32'hBBBB);
    chk(cm_we == 0, "R3 blocked by older", 32'(cm_we), 0);
    do_issue(3, 1, 0, 32'h208);
    #1 chk(opa_wait == 1 && opa_data == 32'hAAAA, "R7 newest only", opa_data, 32'hAAAA);
    do_cmp(4, 32'h55, 0);
    chk(opa_wait == 0 && opa_data == 32'h55, "R7 newest forwards", opa_data, 32'h55);
    do_cmp(2, 32'h44, 0);
    chk(cm_we && cm_addr == 4 && cm_data == 32'h44, "R3 order 1", cm_data, 32'h44);
    tick();
    chk(cm_we && cm_addr == 3 && cm_data == 32'h33, "R3 order 2", cm_data, 32'h33);
    tick();
    chk(cm_we && cm_addr == 3 && cm_data == 32'h55, "R3 order 3", cm_data, 32'h55);
    tick();
    chk(cm_we == 0, "R3 drained", 32'(cm_we), 0);
    src_a = 0; src_b = 0;
  endtask

  task automatic t_store();
    do_issue(0, 0, 1, 32'h300);
    do_cmp(5, 0, 0);
    chk(st_release == 1 && cm_we == 0, "R8 store release", {30'd0, st_release, cm_we}, 2);
    tick();
    chk(st_release == 0, "R8 single pulse", 32'(st_release), 0);
  endtask

  task automatic t_full();
    int first;
    first = exp_tag;
    for (int k = 0; k < DEPTH; k++) do_issue(10 + k, 1, 0, 32'h500 + 4 * k);
    chk(full == 1, "R9 full", 32'(full), 1);
    iss_valid = 1; iss_dst = 7; iss_wen = 1; iss_pc = 32'h5FC;
    tick();
    iss_valid = 0;
    chk(full == 1 && iss_tag == PW'(first), "R9 issue ignored", 32'(iss_tag), 32'(first));
    n_we = 0;
    for (int k = 0; k < DEPTH; k++) do_cmp((first + k) % DEPTH, 32'h70 + k, 0);
    tick(); tick();
    chk(n_we == DEPTH, "R9 R3 all retired", n_we, DEPTH);
    chk(full == 0 && iss_tag == PW'(first), "R1 wrap", 32'(iss_tag), 32'(first));
  endtask

  task automatic t_exc();
    do_issue(5, 1, 0, 32'h400);
    do_issue(6, 1, 0, 32'h404);
    do_cmp(7, 32'h66, 0);
    n_we = 0;
    do_cmp(6, 0, 1);
    chk(cm_we == 0, "R4 faulting not retired", 32'(cm_we), 0);
    tick();
    chk(exc_stop == 1, "R4 stop raised", 32'(exc_stop), 1);
    chk(exc_pc == 32'h400, "R5 saved pc", exc_pc, 32'h400);
    iss_valid = 1; iss_dst = 8; iss_wen = 1;
    tick(); tick();
    iss_valid = 0;
    chk(iss_tag == 0, "R4 issue refused", 32'(iss_tag), 0);
    tick(); tick();
    chk(n_we == 0 && exc_stop == 1, "R4 no later commit", n_we, 0);
    chk(exc_pc == 32'h400, "R5 pc held", exc_pc, 32'h400);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_order();
    t_bypass();
    t_store();
    t_full();
    t_exc();
    do_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule